// File: doc/BRIEF.md
# Timer bus command decoder

This block sits between a host bus and a three-channel interval timer. It watches an active-low chip select, active-low read and write strobes, a 2-bit address and an 8-bit write data bus, all synchronous to one system clock. Three addresses reach the count ports of the three channels. The fourth address is a control port that can only be written.

A host access turns into a single one-cycle pulse. A count write gives a pulse on that channel's write line, with the byte carried beside it. A count read gives a pulse on that channel's read line, and the addressed channel's byte appears on the read data output in the same cycle the read strobe is low. A control write is sorted into one of three commands: a mode program for one channel, a count latch for one channel, or a read-back. The read-back carries a channel mask and can ask for a count latch, a status latch, or both at once. The channels keep the storage and do the counting. This block only decodes and routes.

Top module: `tmr_bus_decoder`

## Requirements
- R1: A write with cs_n=0, wr_n=0, rd_n=1 to address 0, 1 or 2 gives one pulse on cnt_wr_pulse bit 0, 1 or 2. The pulse comes one clock after the first cycle the strobe is sampled low, and cnt_wr_data carries the written byte in that cycle.
- R2: A read with cs_n=0, rd_n=0, wr_n=1 to address 0, 1 or 2 drives rdata with byte lane [8*a+7:8*a] of chan_rdata and sets rdata_oe in every cycle the strobe is held. It also gives one pulse on cnt_rd_pulse bit a, one clock after the first cycle the strobe is low.
- R3: When cs_n is high, when both strobes are high, when both strobes are low, or on a read of address 3, no pulse is produced and rdata_oe stays low with rdata at zero.
- R4: A strobe held low for several cycles produces exactly one pulse. A new pulse needs the strobe (or chip select) to go inactive first.
- R5: On a control write (address 3) whose bits 7:6 are not 11 and bits 5:4 are not 00, the block pulses mode_pulse only on the channel in bits 7:6. It loads cfg_access from bits 5:4 and cfg_bcd from bit 0.
- R6: cfg_mode takes bits 3:1 of that byte, except that codes x10 and x11 become 010 and 011. cfg_mode therefore never exceeds 5.
- R7: A control write with bits 7:6 not 11 and bits 5:4 equal to 00 pulses lat_cnt_pulse for the channel in bits 7:6 only. It gives no mode pulse and leaves cfg_access, cfg_mode and cfg_bcd unchanged.
- R8: A control write with bits 7:6 equal to 11 is a read-back. Channel i is selected by bit i+1. Each selected channel gets a lat_cnt_pulse if bit 5 is 0 and a lat_sts_pulse if bit 4 is 0, both in the same cycle. There is no mode pulse and the cfg outputs are unchanged.
- R9: While rst is high and in the cycle after, all pulse outputs are low and the cfg outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Port address: 0..2 count ports, 3 control port |
| wdata | input | 8 | Write data from host |
| chan_rdata | input | 24 | Read bytes from the channels, channel i in bits [8i+7:8i] |
| rdata | output | 8 | Read data to host, zero when not driven |
| rdata_oe | output | 1 | Read data valid / pad enable |
| cnt_wr_pulse | output | 3 | Per-channel count byte write pulse |
| cnt_rd_pulse | output | 3 | Per-channel count byte read pulse |
| cnt_wr_data | output | 8 | Byte that goes with cnt_wr_pulse |
| mode_pulse | output | 3 | Per-channel mode programming pulse |
| cfg_access | output | 2 | Access format from the last mode command |
| cfg_mode | output | 3 | Normalised mode from the last mode command |
| cfg_bcd | output | 1 | Decimal counting flag from the last mode command |
| lat_cnt_pulse | output | 3 | Per-channel count latch pulse |
| lat_sts_pulse | output | 3 | Per-channel status latch pulse |

## Verification
The hardest case to reach from the ports is a read-back that gives both latch kinds to several channels in one cycle. The same control byte must also leave the stored configuration alone. The bench walks every one of the 256 control bytes in turn. After each byte it compares the per-channel pulse vectors and the held configuration with values worked out from the bit fields. Every mask and count/status combination therefore occurs, and it comes between ordinary mode commands that change the configuration the bench tracks. Strobes held over several cycles, and accesses made with chip select high or with both strobes low, cover the single-pulse and no-operation rules.

// File: rtl/tmr_dec_pkg.sv
package tmr_dec_pkg;

    localparam int CH_COUNT   = 3;
    localparam int BYTE_W     = 8;
    localparam int PORT_AW    = 2;
    localparam logic [1:0] CTRL_ADDR = 2'b11;

    typedef enum logic [1:0] {
        CK_MODE     = 2'd0,
        CK_LATCH    = 2'd1,
        CK_READBACK = 2'd2
    } ctl_kind_e;

    typedef struct packed {
        ctl_kind_e   kind;
        logic [1:0]  chan;
        logic [1:0]  access;
        logic [2:0]  mode;
        logic        bcd;
        logic        want_cnt;
        logic        want_sts;
        logic [2:0]  rb_mask;
    } ctl_cmd_t;

    // codes x10 / x11 fold onto 2 / 3
    function automatic logic [2:0] norm_mode(input logic [2:0] m);
        return m[1] ? {1'b0, m[1:0]} : m;
    endfunction

    function automatic ctl_cmd_t decode_ctl(input logic [7:0] b);
        ctl_cmd_t c;
        c.chan     = b[7:6];
        c.access   = b[5:4];
        c.mode     = norm_mode(b[3:1]);
        c.bcd      = b[0];
        c.want_cnt = ~b[5];
        c.want_sts = ~b[4];
        c.rb_mask  = b[3:1];
        if (b[7:6] == 2'b11)
            c.kind = CK_READBACK;
        else if (b[5:4] == 2'b00)
            c.kind = CK_LATCH;
        else
            c.kind = CK_MODE;
        return c;
    endfunction

endpackage

// File: rtl/tmr_strobe_edge.sv
module tmr_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic start
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active;
    end

    assign start = active & ~active_q;

    // R4: a start is never seen two cycles in a row
    assert_start_once_R4: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

endmodule

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import tmr_dec_pkg::*;
(
    input  logic [7:0] ctl_byte,
    output ctl_cmd_t   cmd
);
    always_comb cmd = decode_ctl(ctl_byte);
endmodule

// File: rtl/tmr_rdata_mux.sv
module tmr_rdata_mux #(
    parameter int NUM_CH = 3,
    parameter int DW     = 8,
    parameter int AW     = 2
) (
    input  logic [NUM_CH*DW-1:0] chan_rdata,
    input  logic [AW-1:0]        addr,
    input  logic                 rd_act,
    output logic [DW-1:0]        rdata,
    output logic                 rdata_oe
);
    logic [NUM_CH-1:0] lane_sel;
    logic [DW-1:0]     lane_and [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        assign lane_sel[i] = rd_act && (addr == AW'(i));
        assign lane_and[i] = lane_sel[i] ? chan_rdata[i*DW +: DW] : '0;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) rdata = rdata | lane_and[i];
    end

    assign rdata_oe = |lane_sel;

    assert_lane_onehot_R2: assert final ($onehot0(lane_sel));

endmodule

// File: rtl/tmr_bus_decoder.sv
module tmr_bus_decoder
    import tmr_dec_pkg::*;
#(
    parameter int NUM_CH = CH_COUNT,
    parameter int DW     = BYTE_W,
    parameter int AW     = PORT_AW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    input  logic [NUM_CH*DW-1:0] chan_rdata,
    output logic [DW-1:0]        rdata,
    output logic                 rdata_oe,
    output logic [NUM_CH-1:0]    cnt_wr_pulse,
    output logic [NUM_CH-1:0]    cnt_rd_pulse,
    output logic [DW-1:0]        cnt_wr_data,
    output logic [NUM_CH-1:0]    mode_pulse,
    output logic [1:0]           cfg_access,
    output logic [2:0]           cfg_mode,
    output logic                 cfg_bcd,
    output logic [NUM_CH-1:0]    lat_cnt_pulse,
    output logic [NUM_CH-1:0]    lat_sts_pulse
);
    localparam logic [AW-1:0] CTRL = AW'(CTRL_ADDR);

    logic wr_act, rd_act, wr_start, rd_start, wr_ctl;
    ctl_cmd_t cmd;

    logic [NUM_CH-1:0] cw_hit, cr_hit, md_hit, lc_hit, ls_hit;

    assign wr_act = ~cs_n & ~wr_n &  rd_n;
    assign rd_act = ~cs_n & ~rd_n &  wr_n;

    tmr_strobe_edge u_wr_edge (.clk(clk), .rst(rst), .active(wr_act), .start(wr_start));
    tmr_strobe_edge u_rd_edge (.clk(clk), .rst(rst), .active(rd_act), .start(rd_start));

    tmr_ctrl_decode u_ctl (.ctl_byte(wdata), .cmd(cmd));

    tmr_rdata_mux #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_mux (
        .chan_rdata(chan_rdata),
        .addr      (addr),
        .rd_act    (rd_act),
        .rdata     (rdata),
        .rdata_oe  (rdata_oe)
    );

    assign wr_ctl = wr_start && (addr == CTRL);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign cw_hit[i] = wr_start && (addr == AW'(i));
        assign cr_hit[i] = rd_start && (addr == AW'(i));
        assign md_hit[i] = wr_ctl && (cmd.kind == CK_MODE) && (cmd.chan == 2'(i));
        assign lc_hit[i] = wr_ctl &&
            (((cmd.kind == CK_LATCH) && (cmd.chan == 2'(i))) ||
             ((cmd.kind == CK_READBACK) && cmd.want_cnt && cmd.rb_mask[i]));
        assign ls_hit[i] = wr_ctl &&
            (cmd.kind == CK_READBACK) && cmd.want_sts && cmd.rb_mask[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_wr_pulse  <= '0;
            cnt_rd_pulse  <= '0;
            cnt_wr_data   <= '0;
            mode_pulse    <= '0;
            lat_cnt_pulse <= '0;
            lat_sts_pulse <= '0;
            cfg_access    <= '0;
            cfg_mode      <= '0;
            cfg_bcd       <= 1'b0;
        end else begin
            cnt_wr_pulse  <= cw_hit;
            cnt_rd_pulse  <= cr_hit;
            mode_pulse    <= md_hit;
            lat_cnt_pulse <= lc_hit;
            lat_sts_pulse <= ls_hit;
            if (|cw_hit) cnt_wr_data <= wdata;
            if (|md_hit) begin
                cfg_access <= cmd.access;
                cfg_mode   <= cmd.mode;
                cfg_bcd    <= cmd.bcd;
            end
        end
    end

    // R1: at most one channel written per access
    assert_wr_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt_wr_pulse));
    // R3: a deselected cycle produces no command in the next cycle
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cnt_wr_pulse == '0 && cnt_rd_pulse == '0 && mode_pulse == '0 &&
                  lat_cnt_pulse == '0 && lat_sts_pulse == '0));
    // R4: read pulses last one cycle
    assert_rd_single_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd_pulse != '0) |=> (cnt_rd_pulse == '0));
    // R5: mode programming reaches one channel only
    assert_mode_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mode_pulse));
    // R6: normalised mode stays in range
    assert_mode_range_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_pulse != '0) |-> (cfg_mode <= 3'd5));
    // R7: latch commands never coincide with mode programming
    assert_latch_no_mode_R7: assert property (@(posedge clk) disable iff (rst)
        ((lat_cnt_pulse | lat_sts_pulse) != '0) |-> (mode_pulse == '0));
    // R8: a latch command keeps the stored configuration
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ((lat_cnt_pulse | lat_sts_pulse) != '0) |-> $stable(cfg_mode));

endmodule

// File: tb/tmr_bus_decoder_tb.sv
module tmr_bus_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, rd_n, wr_n;
    logic [1:0]  addr;
    logic [7:0]  wdata;
    logic [23:0] chan_rdata;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic [2:0]  cnt_wr_pulse, cnt_rd_pulse, mode_pulse, lat_cnt_pulse, lat_sts_pulse;
    logic [7:0]  cnt_wr_data;
    logic [1:0]  cfg_access;
    logic [2:0]  cfg_mode;
    logic        cfg_bcd;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_access = '0;
    logic [2:0] exp_modev  = '0;
    logic       exp_bcdv   = 1'b0;

    always #2 clk = ~clk;

    tmr_bus_decoder dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .chan_rdata(chan_rdata),
        .rdata(rdata), .rdata_oe(rdata_oe),
        .cnt_wr_pulse(cnt_wr_pulse), .cnt_rd_pulse(cnt_rd_pulse),
        .cnt_wr_data(cnt_wr_data), .mode_pulse(mode_pulse),
        .cfg_access(cfg_access), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
        .lat_cnt_pulse(lat_cnt_pulse), .lat_sts_pulse(lat_sts_pulse)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_quiet(input string req);
        chk(req, "wr", 32'(cnt_wr_pulse), 0);
        chk(req, "rd", 32'(cnt_rd_pulse), 0);
        chk(req, "mode", 32'(mode_pulse), 0);
        chk(req, "latc", 32'(lat_cnt_pulse), 0);
        chk(req, "lats", 32'(lat_sts_pulse), 0);
    endtask

    task automatic chk_cfg(input string req);
        chk(req, "access", 32'(cfg_access), 32'(exp_access));
        chk(req, "mode", 32'(cfg_mode), 32'(exp_modev));
        chk(req, "bcd", 32'(cfg_bcd), 32'(exp_bcdv));
    endtask

    // one host access; wr/rd are strobe-active flags
    task automatic access(input bit wr, input bit rd, input bit csn,
                          input logic [1:0] a, input logic [7:0] d,
                          input int hold, input string req);
        bit        wv, rv;
        logic [2:0] e_wr, e_rd, e_md, e_lc, e_ls;
        logic [7:0] e_rdata;
        int m;
        wv = !csn && wr && !rd;
        rv = !csn && rd && !wr;
        e_wr = '0; e_rd = '0; e_md = '0; e_lc = '0; e_ls = '0;
        e_rdata = '0;
        if (wv && a != 2'd3) e_wr[a] = 1'b1;
        if (rv && a != 2'd3) begin
            e_rd[a] = 1'b1;
            e_rdata = chan_rdata[8*a +: 8];
        end
        if (wv && a == 2'd3) begin
            if (d[7:6] == 2'b11) begin
                for (int i = 0; i < 3; i++) begin
                    e_lc[i] = !d[5] && d[i+1];
                    e_ls[i] = !d[4] && d[i+1];
                end
            end else if (d[5:4] == 2'b00) begin
                e_lc[d[7:6]] = 1'b1;
            end else begin
                e_md[d[7:6]] = 1'b1;
            end
        end
        @(negedge clk);
        cs_n = csn; wr_n = !wr; rd_n = !rd; addr = a; wdata = d;
        #1;
        chk("R2", "rdata", 32'(rdata), 32'(e_rdata));
        chk("R3", "oe", 32'(rdata_oe), 32'(rv && a != 2'd3));
        @(negedge clk);
        chk(req, "wr_pulse", 32'(cnt_wr_pulse), 32'(e_wr));
        chk(req, "rd_pulse", 32'(cnt_rd_pulse), 32'(e_rd));
        chk(req, "mode_pulse", 32'(mode_pulse), 32'(e_md));
        chk(req, "lat_cnt", 32'(lat_cnt_pulse), 32'(e_lc));
        chk(req, "lat_sts", 32'(lat_sts_pulse), 32'(e_ls));
        if (e_wr != 0) chk("R1", "wr_data", 32'(cnt_wr_data), 32'(d));
        if (e_md != 0) begin
            m = int'(d[3:1]);
            if (m % 4 >= 2) m = m % 4;
            exp_access = d[5:4];
            exp_modev  = 3'(m);
            exp_bcdv   = d[0];
        end
        chk(req, "cfg", {29'd0, cfg_mode}, 32'(exp_modev));
        chk_cfg(req);
        for (int h = 1; h < hold; h++) begin
            @(negedge clk);
            chk_quiet("R4");
            chk("R4", "held_rdata", 32'(rdata), 32'(e_rdata));
        end
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        chk_quiet("R4");
    endtask

    initial begin
        #400_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        addr = '0; wdata = '0; chan_rdata = 24'h3C_A5_96;
        repeat (3) @(negedge clk);
        chk_quiet("R9");
        chk_cfg("R9");
        rst = 1'b0;
        @(negedge clk);
        chk_quiet("R9");

        // count writes, every address and a spread of bytes
        for (int a = 0; a < 3; a++)
            for (int k = 0; k < 8; k++)
                access(1, 0, 0, 2'(a), 8'(k * 37 + a * 11), 1, "R1");

        // count reads with changing channel data
        for (int k = 0; k < 16; k++) begin
            chan_rdata = {8'(k * 29 + 3), 8'(k * 53 + 7), 8'(k * 17 + 1)};
            for (int a = 0; a < 3; a++)
                access(0, 1, 0, 2'(a), 8'h00, 1, "R2");
        end

        // every control byte, in order and reversed
        for (int b = 0; b < 256; b++) begin
            if (b[7:6] == 2'b11) access(1, 0, 0, 2'd3, 8'(b), 1, "R8");
            else if (b[5:4] == 2'b00) access(1, 0, 0, 2'd3, 8'(b), 1, "R7");
            else access(1, 0, 0, 2'd3, 8'(b), 1, "R5");
        end
        for (int b = 255; b >= 0; b--)
            access(1, 0, 0, 2'd3, 8'(b), 1, "R6");

        // read-back of all channels, count and status together
        access(1, 0, 0, 2'd3, 8'hD5, 1, "R5");
        access(1, 0, 0, 2'd3, 8'hC2 | 8'h0E, 1, "R8");

        // no-operation accesses
        for (int a = 0; a < 4; a++) begin
            access(1, 0, 1, 2'(a), 8'h34, 1, "R3");
            access(0, 1, 1, 2'(a), 8'h00, 1, "R3");
            access(1, 1, 0, 2'(a), 8'h3A, 1, "R3");
            access(0, 0, 0, 2'(a), 8'h36, 1, "R3");
        end
        access(0, 1, 0, 2'd3, 8'h00, 1, "R3");

        // held strobes
        for (int a = 0; a < 4; a++) begin
            access(1, 0, 0, 2'(a), 8'h76, 5, "R4");
            access(0, 1, 0, 2'(a), 8'h00, 4, "R4");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule